// File: doc/BRIEF.md
# Bidirectional Latch/Register Bus Transceiver

This block links two 18-bit ports, A and B, with one storage path per direction. Each path holds a single storage element whose behaviour is chosen by the control levels of that direction. With the latch enable high, the path is transparent: the far-side output follows the near-side input within the same cycle, and the storage follows along. With the latch enable low, the path holds its stored word until a qualified rising edge of the direction's own data clock loads a new one. A qualified edge is a low-to-high step of the data clock while the active-low clock enable is asserted.

The direction clocks are treated as level inputs that are synchronous to the block clock `clk`. A rising step is detected by comparing each clock with its value in the previous cycle, and the load lands on the following `clk` edge. Each port drives a data bus plus an output-enable flag, taken from an active-low enable input. A pad wrapper can join these into an inout bus that floats when the flag is low. The reset is asserted asynchronously, is released through two flops, and clears both stored words.

Top module: `bidir_latreg_xcvr`

## Requirements
- R1: After reset, both stored words are zero, so with both latch enables low, `a_out` and `b_out` read 0.
- R2: While a direction's latch enable is high, its output equals its input in the same cycle (A to `b_out`, B to `a_out`).
- R3: While the latch enable is low and no qualified rising edge of the direction clock occurs, the output keeps its value, even when the input changes or the direction clock sits steady high or low.
- R4: With the latch enable low, a cycle in which the direction clock is 1 after being 0 in the previous cycle, with the clock enable low, loads the input; the output shows it from the next `clk` cycle.
- R5: With the clock enable high (1), a rising step of the direction clock leaves the stored word unchanged.
- R6: The output-enable flag of each port is the inverse of its active-low enable input: `b_oe` = NOT `ab_oe_n` and `a_oe` = NOT `ba_oe_n`.
- R7: When the latch enable falls, the output keeps the last value that passed through while the path was transparent.
- R8: The B-to-A path behaves like the A-to-B path with its own controls, and activity in one direction does not change the other direction's output.
- R9: A falling step of the direction clock does not load the input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low reset, asynchronous assert |
| a_in | input | 18 | A-port input data |
| a_out | output | 18 | A-port output data (B-to-A path) |
| a_oe | output | 1 | A-port drive enable, high drives |
| b_in | input | 18 | B-port input data |
| b_out | output | 18 | B-port output data (A-to-B path) |
| b_oe | output | 1 | B-port drive enable, high drives |
| ab_oe_n | input | 1 | A-to-B output enable, active low |
| ab_le | input | 1 | A-to-B latch enable, high is transparent |
| ab_clk | input | 1 | A-to-B data clock, loads on rising step |
| ab_clken_n | input | 1 | A-to-B clock enable, active low |
| ba_oe_n | input | 1 | B-to-A output enable, active low |
| ba_le | input | 1 | B-to-A latch enable, high is transparent |
| ba_clk | input | 1 | B-to-A data clock, loads on rising step |
| ba_clken_n | input | 1 | B-to-A clock enable, active low |

## Verification
The bench drops the latch enable right after a run of transparent words. A design that did not track the input while transparent would then show a stale word. It holds a direction clock high for many cycles and then drops it. A level-sensitive load, or one that acted on the falling step, would change the output there. It raises the clock with the clock enable deasserted, where an ungated load would overwrite the word, and it works one direction while watching the other for crosstalk, such as a shared clock or swapped controls.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;
  parameter int unsigned XCVR_W = 18;
  localparam int unsigned NDIR = 2;

  typedef struct packed {
    logic oe_n;
    logic le;
    logic dclk;
    logic clken_n;
  } dir_ctrl_t;
endpackage

// File: rtl/xcvr_rst_sync.sv
module xcvr_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_n_sync = chain_q[STAGES-1];
endmodule

// File: rtl/xcvr_edge.sv
module xcvr_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic dclk,
  output logic rise
);
  logic prev_q;

  // Reset to 1 so a clock already high at release is not an edge.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b1;
    else        prev_q <= dclk;
  end

  assign rise = dclk & ~prev_q;
endmodule

// File: rtl/xcvr_cell.sv
module xcvr_cell #(
  parameter int unsigned W = 18
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  input  logic         le,
  input  logic         load,
  output logic [W-1:0] dout
);
  logic [W-1:0] word_q;
  logic [W-1:0] word_d;
  logic         word_en;

  always_comb begin
    word_en = le | load;
    word_d  = word_en ? din : word_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) word_q <= '0;
    else        word_q <= word_d;
  end

  assign dout = le ? din : word_q;
endmodule

// File: rtl/bidir_latreg_xcvr.sv
module bidir_latreg_xcvr
  import xcvr_pkg::*;
#(
  parameter int unsigned W = XCVR_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] a_in,
  output logic [W-1:0] a_out,
  output logic         a_oe,
  input  logic [W-1:0] b_in,
  output logic [W-1:0] b_out,
  output logic         b_oe,
  input  logic         ab_oe_n,
  input  logic         ab_le,
  input  logic         ab_clk,
  input  logic         ab_clken_n,
  input  logic         ba_oe_n,
  input  logic         ba_le,
  input  logic         ba_clk,
  input  logic         ba_clken_n
);
  logic         rst_n_int;
  dir_ctrl_t    ctrl [NDIR];
  logic [W-1:0] din  [NDIR];
  logic [W-1:0] dout [NDIR];
  logic         oe   [NDIR];

  xcvr_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_n_sync(rst_n_int)
  );

  // Index 0: A to B, index 1: B to A.
  assign ctrl[0] = '{oe_n: ab_oe_n, le: ab_le, dclk: ab_clk, clken_n: ab_clken_n};
  assign ctrl[1] = '{oe_n: ba_oe_n, le: ba_le, dclk: ba_clk, clken_n: ba_clken_n};
  assign din[0]  = a_in;
  assign din[1]  = b_in;

  for (genvar d = 0; d < NDIR; d++) begin : g_dir
    logic rise;
    logic load;

    xcvr_edge u_edge (
      .clk(clk), .rst_n(rst_n_int), .dclk(ctrl[d].dclk), .rise(rise)
    );

    assign load = rise & ~ctrl[d].clken_n;

    xcvr_cell #(.W(W)) u_cell (
      .clk(clk), .rst_n(rst_n_int), .din(din[d]), .le(ctrl[d].le),
      .load(load), .dout(dout[d])
    );

    assign oe[d] = ~ctrl[d].oe_n;
  end

  assign b_out = dout[0];
  assign b_oe  = oe[0];
  assign a_out = dout[1];
  assign a_oe  = oe[1];
endmodule

// File: rtl/xcvr_checker.sv
module xcvr_checker #(
  parameter int unsigned W = 18
) (
  input logic         clk,
  input logic         rst_n,
  input logic [W-1:0] a_in,
  input logic [W-1:0] a_out,
  input logic [W-1:0] b_in,
  input logic [W-1:0] b_out,
  input logic         ab_le,
  input logic         ab_clk,
  input logic         ab_clken_n,
  input logic         ba_le,
  input logic         ba_clk,
  input logic         ba_clken_n
);
  logic [2:0] age_q;
  logic       armed;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            age_q <= '0;
    else if (age_q != 3'd7) age_q <= age_q + 3'd1;
  end
  assign armed = (age_q == 3'd7);

  // A to B
  a_r7_fall_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    armed && $fell(ab_le) |-> b_out == $past(a_in));
  a_r4_capture: assert property (@(posedge clk) disable iff (!rst_n)
    armed && !ab_le && $past(!ab_le && ab_clk && !ab_clken_n) && !$past(ab_clk, 2)
    |-> b_out == $past(a_in));
  a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
    armed && !ab_le && $past(!ab_le) &&
    !($past(ab_clk) && !$past(ab_clk, 2) && !$past(ab_clken_n))
    |-> $stable(b_out));
  a_r5_gated: assert property (@(posedge clk) disable iff (!rst_n)
    armed && !ab_le && $past(!ab_le && ab_clken_n) |-> $stable(b_out));

  // B to A mirror (R8, with R7, R4, R3, R5 applied to that path)
  a_r8_ba_fall_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    armed && $fell(ba_le) |-> a_out == $past(b_in));
  a_r8_ba_capture: assert property (@(posedge clk) disable iff (!rst_n)
    armed && !ba_le && $past(!ba_le && ba_clk && !ba_clken_n) && !$past(ba_clk, 2)
    |-> a_out == $past(b_in));
  a_r8_ba_hold: assert property (@(posedge clk) disable iff (!rst_n)
    armed && !ba_le && $past(!ba_le) &&
    !($past(ba_clk) && !$past(ba_clk, 2) && !$past(ba_clken_n))
    |-> $stable(a_out));
  a_r8_ba_gated: assert property (@(posedge clk) disable iff (!rst_n)
    armed && !ba_le && $past(!ba_le && ba_clken_n) |-> $stable(a_out));
endmodule

bind bidir_latreg_xcvr xcvr_checker #(.W(W)) u_chk (.*);

// File: tb/bidir_latreg_xcvr_test.sv
`timescale 1ns/1ps
module bidir_latreg_xcvr_test;
  localparam int W = 18;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [W-1:0] a_in = '0, b_in = '0;
  logic [W-1:0] a_out, b_out;
  logic a_oe, b_oe;
  logic ab_oe_n = 1'b1, ab_le = 1'b0, ab_clk = 1'b0, ab_clken_n = 1'b0;
  logic ba_oe_n = 1'b1, ba_le = 1'b0, ba_clk = 1'b0, ba_clken_n = 1'b0;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  bidir_latreg_xcvr #(.W(W)) uut (.*);

  // Behavioural reference: stored word and last seen clock level per direction.
  logic [W-1:0] m_ab, m_ba;
  bit p_ab, p_ba;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ab <= '0; m_ba <= '0; p_ab <= 1; p_ba <= 1;
    end else begin
      if (ab_le || (ab_clk && !p_ab && !ab_clken_n)) m_ab <= a_in;
      if (ba_le || (ba_clk && !p_ba && !ba_clken_n)) m_ba <= b_in;
      p_ab <= ab_clk;
      p_ba <= ba_clk;
    end
  end

  task automatic chk(string req, logic [W-1:0] act, logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  // Per-cycle comparison against the reference.
  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk(ab_le ? "R2" : "R3", b_out, ab_le ? a_in : m_ab);
      chk(ba_le ? "R2" : "R8", a_out, ba_le ? b_in : m_ba);
      chk("R6", {{(W-1){1'b0}}, b_oe}, {{(W-1){1'b0}}, !ab_oe_n});
      chk("R6", {{(W-1){1'b0}}, a_oe}, {{(W-1){1'b0}}, !ba_oe_n});
    end
  end

  task automatic tick(int n = 1);
    repeat (n) begin @(posedge clk); #2; end
  endtask

  task automatic summary;
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #(20 * 5000);
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    summary();
  end

  initial begin
    tick(3);
    rst_n = 1'b1;
    tick(6);
    chk("R1", b_out, '0);
    chk("R1", a_out, '0);

    // R2 transparent A to B
    ab_le = 1; a_in = 18'h1A5A5; #1;
    chk("R2", b_out, 18'h1A5A5);
    tick(); a_in = 18'h0F0F0; #1;
    chk("R2", b_out, 18'h0F0F0);
    tick();
    // R7 latch enable falls, last word kept
    ab_le = 0; a_in = 18'h3FFFF; #1;
    chk("R7", b_out, 18'h0F0F0);
    tick(3);
    chk("R3", b_out, 18'h0F0F0);

    // R4 qualified rising edge loads
    a_in = 18'h12345; ab_clk = 1; tick();
    chk("R4", b_out, 18'h12345);
    // R3 clock held high, input changes: no load
    a_in = 18'h2AAAA; tick(5);
    chk("R3", b_out, 18'h12345);
    // R9 falling step does not load
    ab_clk = 0; a_in = 18'h15555; tick(2);
    chk("R9", b_out, 18'h12345);

    // R5 clock enable high blocks the edge
    ab_clken_n = 1; a_in = 18'h00777; ab_clk = 1; tick(2);
    chk("R5", b_out, 18'h12345);
    ab_clk = 0; tick(); ab_clken_n = 0; ab_clk = 1; tick();
    chk("R4", b_out, 18'h00777);
    ab_clk = 0; tick();

    // R6 output enables
    ab_oe_n = 0; #1;
    chk("R6", {17'd0, b_oe}, 18'd1);
    ab_oe_n = 1; #1;
    chk("R6", {17'd0, b_oe}, 18'd0);
    ba_oe_n = 0; #1;
    chk("R6", {17'd0, a_oe}, 18'd1);

    // R8 B to A path, A to B must stay
    ba_le = 1; b_in = 18'h0BEEF; #1;
    chk("R8", a_out, 18'h0BEEF);
    chk("R8", b_out, 18'h00777);
    tick(); ba_le = 0; b_in = 18'h0CAFE; tick();
    chk("R8", a_out, 18'h0BEEF);
    ba_clk = 1; tick();
    chk("R8", a_out, 18'h0CAFE);
    chk("R8", b_out, 18'h00777);
    ba_clk = 0; ba_clken_n = 1; b_in = 18'h01111; tick(); ba_clk = 1; tick(2);
    chk("R5", a_out, 18'h0CAFE);
    // A-to-B edge must not touch B-to-A
    ba_clk = 0; ba_clken_n = 0; tick();
    a_in = 18'h24680; ab_clk = 1; tick();
    chk("R8", b_out, 18'h24680);
    chk("R8", a_out, 18'h0CAFE);
    ab_clk = 0; ba_oe_n = 1; tick(4);

    summary();
  end
endmodule